// File: doc/BRIEF.md
# Twelve-Pin GPIO Bank with Power-Up Defaults

This block controls twelve general-purpose pins through two sets of byte registers. The default set holds the values the pins should take after power-up: output level, direction, read inversion, output type per group of four pins, and a switching mode shared by all pins. The working set is what actually drives the pins. When reset is released, a short sequencer copies each default register into its working register, one register per clock, and reports itself busy while it does so.

A byte-wide register bus with a combinational read path gives access to both sets and to two read-only registers that return the synchronised pin levels, each optionally inverted. Pins are modelled as a separate output value and output enable. An output may be push-pull or open drain. In open drain it only pulls low. Output level changes reach the pins either all in the same clock, or one pin per clock in ascending pin order.

Address map (4-bit address): 0x0 default level pins 0-7, 0x1 default level pins 8-11, 0x2 default direction pins 0-7, 0x3 default direction pins 8-11, 0x4 default inversion pins 0-7, 0x5 default config. 0x8 to 0xD are the working copies in the same order. 0xE and 0xF are the pin-read registers for pins 0-7 and 8-11. 0x6 and 0x7 read as zero. In each register pair, the low byte holds pins 0-7 (bit n = pin n) and bits 3:0 of the high byte hold pins 8-11. Config byte layout: bits 3:0 are the inversion bits for pins 8-11. Bits 4, 5 and 6 are the output type for pins 0-3, 4-7 and 8-11 (1 = open drain). Bit 7 is the switching mode (1 = one pin per clock).

Top module: `gpio_bank`

## Requirements
- R1: After reset is released, `busy` is 1 for exactly 6 rising edges. Then the working registers 0x8-0xD equal the default registers 0x0-0x5. The factory defaults are FF, 0F, FF, 0F, 00 and 80.
- R2: While `busy` is 1, bus writes change no register and `bus_rdata` reads 0.
- R3: Bits 7:4 of the pin 8-11 registers (0x1, 0x3, 0x9, 0xB, 0xF) always read 0, whatever was written.
- R4: A direction bit of 1 makes the pin an input (`pad_oe`=0). A bit of 0 makes it an output. In push-pull, the output has `pad_oe`=1 and `pad_out` equal to the applied level.
- R5: In an open-drain group, an output pin has `pad_out`=0, and `pad_oe`=1 only while its applied level is 0.
- R6: With config bit 7 = 1, the applied levels move toward the working level register by one pin per clock, lowest differing pin first.
- R7: With config bit 7 = 0, every pin takes the new working level on the first rising edge after the edge that wrote it.
- R8: Reads of 0xE/0xF return the pin inputs delayed by two rising edges, XORed with the working inversion bits.
- R9: Writes to 0xE, 0xF, 0x6 and 0x7 change no register.
- R10: Writes to the default registers are read back but do not alter the working registers or the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| busy | output | 1 | Power-up copy in progress |
| pad_in | input | 12 | Sampled pin levels |
| pad_out | output | 12 | Pin output value |
| pad_oe | output | 12 | Pin output enable |

## Verification
The assertions assume that `pad_in` is asynchronous, and they make no claim about its value before it has passed through the synchroniser. The assertions on stepping and following assume that the working level register changes only through bus writes. The stimulus changes `pad_in` only away from clock edges. It waits out the two-edge synchroniser delay before it expects a new pin value. It issues bus writes only one clock wide, so that each expected pin pattern can be tied to the edge that caused it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int NPINS  = 12;
   localparam int GRP    = 4;
   localparam int NGRP   = NPINS / GRP;
   localparam int NREG   = 6;
   localparam int ADDR_W = 4;

   // Register index within a set; the working set sits at index + 8.
   localparam logic [2:0] IX_LVL_LO = 3'd0;
   localparam logic [2:0] IX_LVL_HI = 3'd1;
   localparam logic [2:0] IX_DIR_LO = 3'd2;
   localparam logic [2:0] IX_DIR_HI = 3'd3;
   localparam logic [2:0] IX_INV_LO = 3'd4;
   localparam logic [2:0] IX_CFG    = 3'd5;
   localparam logic [2:0] IX_PIN_LO = 3'd6;
   localparam logic [2:0] IX_PIN_HI = 3'd7;

   // Registers that hold pins 8-11 keep only their low nibble.
   function automatic logic [7:0] keep_mask(input logic [2:0] ix);
      return (ix == IX_LVL_HI || ix == IX_DIR_HI) ? 8'h0F : 8'hFF;
   endfunction
endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
   import gpio_bank_pkg::*;
#(
   parameter logic [NPINS-1:0] DEF_LVL  = 12'hFFF,
   parameter logic [NPINS-1:0] DEF_DIR  = 12'hFFF,
   parameter logic [NPINS-1:0] DEF_INV  = 12'h000,
   parameter logic [NGRP-1:0]  DEF_OD   = 3'b000,
   parameter logic             DEF_SEQ  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic [NPINS-1:0]  pin_val,
   output logic [7:0]        rdata,
   output logic              busy,
   output logic [NPINS-1:0]  lvl_vec,
   output logic [NPINS-1:0]  dir_vec,
   output logic [NPINS-1:0]  inv_vec,
   output logic [NGRP-1:0]   od_vec,
   output logic              seq_mode
);
   localparam logic [2:0] LAST_IX = 3'(NREG - 1);
   localparam logic [NREG-1:0][7:0] FACTORY = {
      {DEF_SEQ, DEF_OD, DEF_INV[11:8]}, DEF_INV[7:0],
      {4'h0, DEF_DIR[11:8]}, DEF_DIR[7:0],
      {4'h0, DEF_LVL[11:8]}, DEF_LVL[7:0]};
   // Working set before the copy: all pins inputs, nothing driven.
   localparam logic [NREG-1:0][7:0] SAFE = {8'h00, 8'h00, 8'h0F, 8'hFF, 8'h00, 8'h00};

   initial begin
      if (NPINS != 12 || NGRP != 3) $error("gpio_reg_file: byte packing assumes 12 pins in 3 groups");
   end

   logic [NREG-1:0][7:0] dflt_q, work_q;
   logic [2:0]           cp_ix;
   logic                 busy_q;
   logic                 in_work, ix_hit;
   logic [2:0]           ix;

   assign in_work = bus_addr[3];
   assign ix      = bus_addr[2:0];
   assign ix_hit  = (ix <= LAST_IX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         cp_ix  <= '0;
      end else if (busy_q) begin
         if (cp_ix == LAST_IX) busy_q <= 1'b0;
         else                  cp_ix  <= cp_ix + 3'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dflt_q <= FACTORY;
      else if (bus_wr && !busy_q && !in_work && ix_hit)
         dflt_q[ix] <= bus_wdata & keep_mask(ix);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         work_q <= SAFE;
      else if (busy_q)
         work_q[cp_ix] <= dflt_q[cp_ix];
      else if (bus_wr && in_work && ix_hit)
         work_q[ix] <= bus_wdata & keep_mask(ix);
   end

   always_comb begin
      rdata = '0;
      if (!busy_q) begin
         if (in_work) begin
            if (ix_hit)                rdata = work_q[ix];
            else if (ix == IX_PIN_LO)  rdata = pin_val[7:0];
            else                       rdata = {4'h0, pin_val[11:8]};
         end else if (ix_hit) begin
            rdata = dflt_q[ix];
         end
      end
   end

   assign busy     = busy_q;
   assign lvl_vec  = {work_q[IX_LVL_HI][3:0], work_q[IX_LVL_LO]};
   assign dir_vec  = {work_q[IX_DIR_HI][3:0], work_q[IX_DIR_LO]};
   assign inv_vec  = {work_q[IX_CFG][3:0],    work_q[IX_INV_LO]};
   assign od_vec   = work_q[IX_CFG][6:4];
   assign seq_mode = work_q[IX_CFG][7];

   // R1: the copy runs once; busy never returns without a reset
   a_r1_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> !busy_q);
   // R2: a write attempted during the copy leaves the default set untouched
   a_r2_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bus_wr) |=> $stable(dflt_q));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pad_in,
   input  logic [WIDTH-1:0] inv,
   output logic [WIDTH-1:0] pin_val
);
   generate
      if (STAGES < 2) begin : g_bad
         initial $error("gpio_pin_sync: at least two stages required");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] sq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= '0;
      else        sq <= {sq[STAGES-2:0], pad_in};
   end

   assign pin_val = sq[STAGES-1] ^ inv;
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
   parameter int WIDTH = 12,
   parameter int GRP   = 4,
   localparam int NG   = WIDTH / GRP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] target,
   input  logic [WIDTH-1:0] dir,
   input  logic [NG-1:0]    od,
   input  logic             seq_mode,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   generate
      if (WIDTH % GRP != 0) begin : g_bad
         initial $error("gpio_drive: width must be a whole number of groups");
      end
   endgenerate

   logic [WIDTH-1:0] applied_q, diff, lowest, nxt;

   always_comb begin
      diff   = applied_q ^ target;
      lowest = diff & (~diff + WIDTH'(1));
      nxt    = seq_mode ? (applied_q ^ lowest) : target;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) applied_q <= '0;
      else        applied_q <= nxt;
   end

   generate
      for (genvar p = 0; p < WIDTH; p++) begin : g_pin
         localparam int G = p / GRP;
         assign pad_oe[p]  = ~dir[p] & (~od[G] | ~applied_q[p]);
         assign pad_out[p] = applied_q[p] & ~od[G];
      end
   endgenerate

   // R6: in stepping mode at most one pin changes per clock
   a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      seq_mode |=> ($countones(applied_q ^ $past(applied_q)) <= 1));
   // R7: in simultaneous mode the applied levels follow the target one clock later
   a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_mode |=> (applied_q == $past(target)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [NPINS-1:0] DEF_LVL     = 12'hFFF,
   parameter logic [NPINS-1:0] DEF_DIR     = 12'hFFF,
   parameter logic [NPINS-1:0] DEF_INV     = 12'h000,
   parameter logic [NGRP-1:0]  DEF_OD      = 3'b000,
   parameter logic             DEF_SEQ     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              busy,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);
   logic [NPINS-1:0] lvl_vec, dir_vec, inv_vec, pin_val;
   logic [NGRP-1:0]  od_vec;
   logic             seq_mode;

   gpio_reg_file #(
      .DEF_LVL(DEF_LVL), .DEF_DIR(DEF_DIR), .DEF_INV(DEF_INV),
      .DEF_OD(DEF_OD), .DEF_SEQ(DEF_SEQ)
   ) u_regs (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
      .pin_val(pin_val), .rdata(bus_rdata), .busy(busy),
      .lvl_vec(lvl_vec), .dir_vec(dir_vec), .inv_vec(inv_vec),
      .od_vec(od_vec), .seq_mode(seq_mode)
   );

   gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .pad_in, .inv(inv_vec), .pin_val(pin_val)
   );

   gpio_drive #(.WIDTH(NPINS), .GRP(GRP)) u_drive (
      .clk, .rst_n, .target(lvl_vec), .dir(dir_vec), .od(od_vec),
      .seq_mode(seq_mode), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // R4: a pin configured as input is never driven
   a_r4_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & dir_vec) == '0);
   // R3: registers for pins 8-11 read zero in their upper nibble
   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 4'h1 || bus_addr == 4'h3 || bus_addr == 4'h9 ||
       bus_addr == 4'hB || bus_addr == 4'hF) |-> (bus_rdata[7:4] == 4'h0));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
   localparam time TCLK = 10ns;

   typedef struct {
      int          kind;   // 0 rdata, 1 pad_out, 2 pad_oe, 3 busy
      int          req;
      logic [11:0] exp;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        busy;
   logic [11:0] pad_in = '0;
   logic [11:0] pad_out, pad_oe;

   item_t sbq[$];
   int    n_chk = 0, n_fail = 0;
   bit    done = 0;

   always #(TCLK/2) clk = ~clk;

   gpio_bank u0 (.*);

   // monitor: compares every expectation queued in this half cycle
   initial forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
         item_t it;
         logic [11:0] act;
         it = sbq.pop_front();
         case (it.kind)
            0: act = {4'h0, bus_rdata};
            1: act = pad_out;
            2: act = pad_oe;
            default: act = {11'h0, busy};
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL R%0d kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic sb_push(int kind, int req, logic [11:0] e);
      item_t it;
      it.kind = kind; it.req = req; it.exp = e;
      sbq.push_back(it);
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      step();
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, logic [7:0] e, int req);
      step();
      bus_addr = a;
      sb_push(0, req, {4'h0, e});
   endtask

   task automatic chk(int req, int act, int e);
      n_chk++;
      if (act != e) begin
         n_fail++;
         $display("FAIL R%0d actual=%0d expected=%0d", req, act, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int cyc;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      sb_push(3, 1, 12'h001);                 // R1: busy right after reset
      bus_addr = 4'h8; bus_wdata = 8'h00; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0; bus_addr = 4'h0;
      sb_push(0, 2, 12'h000);                 // R2: read while busy gives 0
      cyc = 1;
      while (busy) begin step(); cyc++; end
      chk(1, cyc, 6);                         // R1: copy lasts six edges
      // R1: factory defaults and their copies
      rd(4'h0, 8'hFF, 1); rd(4'h1, 8'h0F, 1); rd(4'h2, 8'hFF, 1);
      rd(4'h3, 8'h0F, 1); rd(4'h4, 8'h00, 1); rd(4'h5, 8'h80, 1);
      rd(4'h8, 8'hFF, 2);                     // R2: write during busy was dropped
      rd(4'h9, 8'h0F, 1); rd(4'hA, 8'hFF, 1); rd(4'hB, 8'h0F, 1);
      rd(4'hC, 8'h00, 1); rd(4'hD, 8'h80, 1);
      repeat (14) step();
      sb_push(1, 6, 12'hFFF);                 // R6: stepping ramp finished
      sb_push(2, 4, 12'h000);                 // R4: all inputs, nothing driven
      // R3: reserved nibble
      wr(4'h9, 8'hF5); rd(4'h9, 8'h05, 3);
      wr(4'h1, 8'hAA); rd(4'h1, 8'h0A, 3);
      // simultaneous push-pull, all outputs
      wr(4'hD, 8'h00); wr(4'hA, 8'h00); wr(4'hB, 8'h00);
      step();
      sb_push(2, 4, 12'hFFF);                 // R4: outputs enabled
      sb_push(1, 4, 12'h5FF);                 // R4: push-pull value
      // R7: all pins one edge after the write
      wr(4'h8, 8'h3C);
      sb_push(1, 7, 12'h5FF);
      step();
      sb_push(1, 7, 12'h53C);
      // R4: direction 1 releases pins 8-11
      wr(4'hB, 8'h0F); sb_push(2, 4, 12'h0FF);
      wr(4'hB, 8'h00); sb_push(2, 4, 12'hFFF);
      // R5: open drain on pins 0-3, then on all groups
      wr(4'hD, 8'h10); sb_push(2, 5, 12'hFF3); sb_push(1, 5, 12'h530);
      wr(4'hD, 8'h70); sb_push(2, 5, 12'hAC3); sb_push(1, 5, 12'h000);
      // R6: pins 0, 3, 5 flip one per clock in ascending order
      wr(4'hD, 8'h80);
      wr(4'h8, 8'h15);
      sb_push(1, 6, 12'h53C);
      step(); sb_push(1, 6, 12'h53D);
      step(); sb_push(1, 6, 12'h535);
      step(); sb_push(1, 6, 12'h515);
      step(); sb_push(1, 6, 12'h515);
      // R8: pin read with inversion and two-edge synchroniser
      wr(4'hD, 8'h05); wr(4'hC, 8'h0F);
      step();
      pad_in = 12'hA5C; bus_addr = 4'hE;
      sb_push(0, 8, 12'h00F);
      step(); sb_push(0, 8, 12'h00F);
      step(); sb_push(0, 8, 12'h053);
      rd(4'hF, 8'h0F, 8);
      // R9: read-only and empty addresses ignore writes
      wr(4'hE, 8'h00); rd(4'hE, 8'h53, 9);
      wr(4'hF, 8'hFF); rd(4'hF, 8'h0F, 9);
      wr(4'h6, 8'hFF); rd(4'h6, 8'h00, 9);
      wr(4'h7, 8'hFF); rd(4'h7, 8'h00, 9);
      rd(4'h8, 8'h15, 9); rd(4'hC, 8'h0F, 9);
      // R10: default writes stay in the default set
      wr(4'h0, 8'h12); rd(4'h0, 8'h12, 10);
      rd(4'h8, 8'h15, 10);
      step(); sb_push(1, 10, 12'h515);
      step(); step();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule